// File: doc/BRIEF.md
# PC Card ATA Task-File Address Decoder

This block sits between a PC Card host access path and an ATA register file. A host read or write arrives with an address, and the block turns it into one of sixteen task-file slot numbers. The option register's 6-bit addressing mode decides how the address is folded. There are four folds: a memory-mapped layout, a contiguous 16-byte I/O layout, and the primary and secondary legacy I/O layouts. The legacy layouts each split into a command-block window and an alternate-status window.

The block serves the card-specific slots itself. These are the data aliases, the odd-byte data latch, the error/features pair, the alternate-status/device-control pair and a synthesized device address register. Every other slot is forwarded to the ATA register file with a one-cycle read or write strobe. Read data is combinational from the selected slot. The only state in the block is the odd-byte latch and its byte-cycle flag.

Top module: `tf_slot_decoder`

## Requirements
- R1: After reset, the latched odd byte reads 0x00 and the byte-cycle flag is 0.
- R2: In mode 0, any address from 0x400 to 0x7FF selects slot 0.
- R3: In mode 1, the slot is the low 4 bits of the address.
- R4: In mode 2, addresses 0x1F0–0x1FF give slot (address − 0x1F0) and addresses 0x3F0–0x3FF give the low 4 bits of (address − 0x3E8). For example, 0x3F6 gives slot 0xE and 0x3F7 gives slot 0xF.
- R5: In mode 3, addresses 0x170–0x17F give slot (address − 0x170) and addresses 0x370–0x37F give the low 4 bits of (address − 0x368).
- R6: In modes 4 to 63, and for any address outside the active mode's windows, the slot is the low 4 bits of the address.
- R7: Slots 0 and 8 both reach the 16-bit data register. A read raises only dataRdStb, a write raises only dataWrStb, coreRegIdx is 0 and rdData equals coreRdData.
- R8: Slot 0xD maps to core register index 1. A read raises coreRdStb (the error register), a write raises coreWrStb (the features register), and rdData equals coreRdData.
- R9: A read of slot 0xE returns coreStatus in bits 7:0 when drivePresent is 1, and 0 otherwise, with no strobe. A write to slot 0xE raises only devCtrlWrStb.
- R10: A read of slot 0xF returns 0xC2 | ((~devHeadLow << 2) & 0x3C) with no strobe. A write to slot 0xF is forwarded as a core write with index 0xF.
- R11: A write to slot 9 raises no output strobe. After the next clock edge, oddByte holds wrLowByte and byteCycle has toggled. A read of slot 9 returns oddByte zero-extended, with no strobe. No other access changes either value.
- R12: Slots 1–7 and 0xA–0xC are forwarded with coreRegIdx equal to the slot. A read raises coreRdStb, a write raises coreWrStb, and rdData equals coreRdData.
- R13: Strobes are raised only in a cycle with rdStb or wrStb high, and at most one is raised at a time. When both rdStb and wrStb are high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 6 | Addressing mode from the option register |
| accAddr | input | 16 | Host access address |
| rdStb | input | 1 | Host read, one cycle per access |
| wrStb | input | 1 | Host write, one cycle per access |
| wrLowByte | input | 8 | Low byte of the host write value |
| devHeadLow | input | 4 | Low nibble of the drive/head select register |
| coreStatus | input | 8 | Current drive status |
| drivePresent | input | 1 | A drive is attached |
| coreRdData | input | 16 | Read value returned by the ATA register file |
| slotIdx | output | 4 | Decoded task-file slot |
| coreRegIdx | output | 4 | Register index presented to the ATA register file |
| coreRdStb | output | 1 | Forwarded register read |
| coreWrStb | output | 1 | Forwarded register write |
| dataRdStb | output | 1 | Data register read |
| dataWrStb | output | 1 | Data register write |
| devCtrlWrStb | output | 1 | Device control register write |
| rdData | output | 16 | Read data for the selected slot |
| oddByte | output | 8 | Latched odd data byte |
| byteCycle | output | 1 | Byte-cycle flag |

## Verification
The slot number, the strobes, the register index and the read data are all combinational. Each is due in the same cycle the address and strobes are applied. The odd-byte latch and the byte-cycle flag change only at the rising edge that ends a slot-9 write, so their new values are due one cycle later.

The bench applies inputs at the falling edge and compares every output with its behavioural model 1 ns later. It advances the model's latch state only at the rising edge. A late or early update of the latch therefore shows up as a mismatch in the following comparison.

// File: rtl/tf_slot_pkg.sv
package tf_slot_pkg;

  localparam int SLOT_W = 4;

  // addressing modes carried in the option register
  localparam int MODE_MEMMAP    = 0;
  localparam int MODE_IO16      = 1;
  localparam int MODE_PRIMARY   = 2;
  localparam int MODE_SECONDARY = 3;

  // slots the decoder serves itself
  localparam logic [SLOT_W-1:0] SLOT_DATA    = 4'h0;
  localparam logic [SLOT_W-1:0] SLOT_DATA_HI = 4'h8;
  localparam logic [SLOT_W-1:0] SLOT_ODD     = 4'h9;
  localparam logic [SLOT_W-1:0] SLOT_ERRFEAT = 4'hD;
  localparam logic [SLOT_W-1:0] SLOT_ALTCTL  = 4'hE;
  localparam logic [SLOT_W-1:0] SLOT_DEVADDR = 4'hF;

  // core register that holds error (read) and features (write)
  localparam logic [SLOT_W-1:0] CORE_ERR_IDX = 4'h1;

  // fixed bits of the synthesized device address register
  localparam logic [7:0] DEVADDR_FIXED = 8'hC2;

  typedef struct packed {
    logic dataRd;
    logic dataWr;
    logic coreRd;
    logic coreWr;
    logic ctrlWr;
    logic oddWr;
  } tfStrobes_t;

endpackage

// File: rtl/tf_legacy_window.sv
module tf_legacy_window #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 4,
  parameter logic [ADDR_W-1:0] TASK_BASE = 16'h01F0,
  parameter logic [ADDR_W-1:0] ALT_BASE  = 16'h03F0,
  parameter logic [ADDR_W-1:0] ALT_ADJ   = 16'h03E8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);

  logic inTask;
  logic inAlt;

  // both windows are aligned 2**SLOT_W byte blocks
  assign inTask = (addr[ADDR_W-1:SLOT_W] == TASK_BASE[ADDR_W-1:SLOT_W]);
  assign inAlt  = (addr[ADDR_W-1:SLOT_W] == ALT_BASE[ADDR_W-1:SLOT_W]);
  assign hit    = inTask | inAlt;

  // only the low bits of the difference survive into the slot number
  assign slot = inAlt ? (addr[SLOT_W-1:0] - ALT_ADJ[SLOT_W-1:0])
                      : (addr[SLOT_W-1:0] - TASK_BASE[SLOT_W-1:0]);

endmodule

// File: rtl/tf_slot_ctrl.sv
module tf_slot_ctrl
  import tf_slot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MODE_W = 6,
  parameter logic [ADDR_W-1:0] PRI_TASK_BASE = 16'h01F0,
  parameter logic [ADDR_W-1:0] PRI_ALT_BASE  = 16'h03F0,
  parameter logic [ADDR_W-1:0] PRI_ALT_ADJ   = 16'h03E8,
  parameter logic [ADDR_W-1:0] SEC_TASK_BASE = 16'h0170,
  parameter logic [ADDR_W-1:0] SEC_ALT_BASE  = 16'h0370,
  parameter logic [ADDR_W-1:0] SEC_ALT_ADJ   = 16'h0368,
  parameter int MEM_WIN_BASE  = 'h400,
  parameter int MEM_WIN_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] coreIdx,
  output tfStrobes_t        stb
);

  localparam int NUM_LEGACY = 2;
  localparam int MEM_TAG_W  = ADDR_W - MEM_WIN_SHIFT;
  localparam logic [MEM_TAG_W-1:0] MEM_TAG = MEM_TAG_W'(MEM_WIN_BASE >> MEM_WIN_SHIFT);

  logic [NUM_LEGACY-1:0] winHit;
  logic [SLOT_W-1:0]     winSlot [NUM_LEGACY];
  logic                  memHit;
  logic                  isWr;
  logic                  isRd;

  // one window pair per legacy I/O layout: index 0 primary, 1 secondary
  for (genvar g = 0; g < NUM_LEGACY; g++) begin : g_legacy
    tf_legacy_window #(
      .ADDR_W   (ADDR_W),
      .SLOT_W   (SLOT_W),
      .TASK_BASE(g == 0 ? PRI_TASK_BASE : SEC_TASK_BASE),
      .ALT_BASE (g == 0 ? PRI_ALT_BASE  : SEC_ALT_BASE),
      .ALT_ADJ  (g == 0 ? PRI_ALT_ADJ   : SEC_ALT_ADJ)
    ) u_win (
      .addr(accAddr),
      .hit (winHit[g]),
      .slot(winSlot[g])
    );
  end

  assign memHit = (accAddr[ADDR_W-1:MEM_WIN_SHIFT] == MEM_TAG);

  always_comb begin
    slot = accAddr[SLOT_W-1:0];
    if (modeSel == MODE_W'(MODE_MEMMAP) && memHit) begin
      slot = SLOT_DATA;
    end else if (modeSel == MODE_W'(MODE_PRIMARY) && winHit[0]) begin
      slot = winSlot[0];
    end else if (modeSel == MODE_W'(MODE_SECONDARY) && winHit[1]) begin
      slot = winSlot[1];
    end
  end

  // a simultaneous read and write is taken as a write
  assign isWr = wrStb;
  assign isRd = rdStb & ~wrStb;

  always_comb begin
    stb     = '0;
    coreIdx = slot;
    unique case (slot)
      SLOT_DATA, SLOT_DATA_HI: begin
        stb.dataRd = isRd;
        stb.dataWr = isWr;
        coreIdx    = '0;
      end
      SLOT_ODD: begin
        stb.oddWr = isWr;
      end
      SLOT_ERRFEAT: begin
        coreIdx    = CORE_ERR_IDX;
        stb.coreRd = isRd;
        stb.coreWr = isWr;
      end
      SLOT_ALTCTL: begin
        stb.ctrlWr = isWr;
      end
      SLOT_DEVADDR: begin
        stb.coreWr = isWr;
      end
      default: begin
        stb.coreRd = isRd;
        stb.coreWr = isWr;
      end
    endcase
  end

  // R13: never more than one strobe per access
  assert_single_strobe_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R13: no strobe without a host access
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb && !wrStb) |-> (stb == '0));

endmodule

// File: rtl/tf_slot_dpath.sv
module tf_slot_dpath
  import tf_slot_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] slot,
  input  tfStrobes_t        stb,
  input  logic [7:0]        wrLowByte,
  input  logic [3:0]        devHeadLow,
  input  logic [7:0]        coreStatus,
  input  logic              drivePresent,
  input  logic [DATA_W-1:0] coreRdData,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        oddByte,
  output logic              byteCycle
);

  logic [7:0] devAddr;
  logic [7:0] altStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddByte   <= '0;
      byteCycle <= 1'b0;
    end else if (stb.oddWr) begin
      oddByte   <= wrLowByte;
      byteCycle <= ~byteCycle;
    end
  end

  // device address register: fixed bits plus inverted head-select nibble
  assign devAddr   = DEVADDR_FIXED | {2'b00, ~devHeadLow, 2'b00};
  assign altStatus = drivePresent ? coreStatus : 8'h00;

  always_comb begin
    unique case (slot)
      SLOT_ODD:     rdData = DATA_W'(oddByte);
      SLOT_ALTCTL:  rdData = DATA_W'(altStatus);
      SLOT_DEVADDR: rdData = DATA_W'(devAddr);
      default:      rdData = coreRdData;
    endcase
  end

  // R11: a slot-9 write latches the byte and flips the flag
  assert_odd_latch_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.oddWr |=> (oddByte == $past(wrLowByte)) && (byteCycle != $past(byteCycle)));

  // R11: every other access leaves the latch untouched
  assert_odd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.oddWr |=> $stable(oddByte) && $stable(byteCycle));

  // R10: fixed bits of the device address read
  assert_devaddr_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (slot == SLOT_DEVADDR) |-> (rdData[DATA_W-1:8] == '0) && (rdData[7:6] == 2'b11)
                               && (rdData[1:0] == 2'b10));

  // R9: alternate status of an absent drive reads zero
  assert_altstat_absent_R9: assert property (@(posedge clk) disable iff (!rstN)
    (slot == SLOT_ALTCTL && !drivePresent) |-> (rdData == '0));

endmodule

// File: rtl/tf_slot_decoder.sv
module tf_slot_decoder
  import tf_slot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MODE_W = 6,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PRI_TASK_BASE = 16'h01F0,
  parameter logic [ADDR_W-1:0] PRI_ALT_BASE  = 16'h03F0,
  parameter logic [ADDR_W-1:0] PRI_ALT_ADJ   = 16'h03E8,
  parameter logic [ADDR_W-1:0] SEC_TASK_BASE = 16'h0170,
  parameter logic [ADDR_W-1:0] SEC_ALT_BASE  = 16'h0370,
  parameter logic [ADDR_W-1:0] SEC_ALT_ADJ   = 16'h0368,
  parameter int MEM_WIN_BASE  = 'h400,
  parameter int MEM_WIN_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [7:0]        wrLowByte,
  input  logic [3:0]        devHeadLow,
  input  logic [7:0]        coreStatus,
  input  logic              drivePresent,
  input  logic [DATA_W-1:0] coreRdData,
  output logic [3:0]        slotIdx,
  output logic [3:0]        coreRegIdx,
  output logic              coreRdStb,
  output logic              coreWrStb,
  output logic              dataRdStb,
  output logic              dataWrStb,
  output logic              devCtrlWrStb,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        oddByte,
  output logic              byteCycle
);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] coreIdx;
  tfStrobes_t        stb;

  tf_slot_ctrl #(
    .ADDR_W       (ADDR_W),
    .MODE_W       (MODE_W),
    .PRI_TASK_BASE(PRI_TASK_BASE),
    .PRI_ALT_BASE (PRI_ALT_BASE),
    .PRI_ALT_ADJ  (PRI_ALT_ADJ),
    .SEC_TASK_BASE(SEC_TASK_BASE),
    .SEC_ALT_BASE (SEC_ALT_BASE),
    .SEC_ALT_ADJ  (SEC_ALT_ADJ),
    .MEM_WIN_BASE (MEM_WIN_BASE),
    .MEM_WIN_SHIFT(MEM_WIN_SHIFT)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .accAddr(accAddr),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .slot   (slot),
    .coreIdx(coreIdx),
    .stb    (stb)
  );

  tf_slot_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .slot        (slot),
    .stb         (stb),
    .wrLowByte   (wrLowByte),
    .devHeadLow  (devHeadLow),
    .coreStatus  (coreStatus),
    .drivePresent(drivePresent),
    .coreRdData  (coreRdData),
    .rdData      (rdData),
    .oddByte     (oddByte),
    .byteCycle   (byteCycle)
  );

  assign slotIdx      = slot;
  assign coreRegIdx   = coreIdx;
  assign coreRdStb    = stb.coreRd;
  assign coreWrStb    = stb.coreWr;
  assign dataRdStb    = stb.dataRd;
  assign dataWrStb    = stb.dataWr;
  assign devCtrlWrStb = stb.ctrlWr;

endmodule

// File: tb/tf_slot_decoder_bench.sv
`timescale 1ns/1ps
module tf_slot_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  modeSel = '0;
  logic [15:0] accAddr = '0;
  logic        rdStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [7:0]  wrLowByte = '0;
  logic [3:0]  devHeadLow = '0;
  logic [7:0]  coreStatus = '0;
  logic        drivePresent = 1'b0;
  logic [15:0] coreRdData = '0;
  logic [3:0]  slotIdx, coreRegIdx;
  logic        coreRdStb, coreWrStb, dataRdStb, dataWrStb, devCtrlWrStb;
  logic [15:0] rdData;
  logic [7:0]  oddByte;
  logic        byteCycle;

  int checks = 0;
  int failures = 0;
  int mOdd = 0;
  int mCyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tf_slot_decoder u_tf_slot_decoder (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .accAddr(accAddr),
    .rdStb(rdStb), .wrStb(wrStb), .wrLowByte(wrLowByte),
    .devHeadLow(devHeadLow), .coreStatus(coreStatus),
    .drivePresent(drivePresent), .coreRdData(coreRdData),
    .slotIdx(slotIdx), .coreRegIdx(coreRegIdx), .coreRdStb(coreRdStb),
    .coreWrStb(coreWrStb), .dataRdStb(dataRdStb), .dataWrStb(dataWrStb),
    .devCtrlWrStb(devCtrlWrStb), .rdData(rdData), .oddByte(oddByte),
    .byteCycle(byteCycle)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural slot model
  function automatic int refSlot(input int mode, input int addr);
    if (mode == 0 && addr >= 'h400 && addr <= 'h7FF) return 0;
    if (mode == 2 && addr >= 'h1F0 && addr <= 'h1FF) return (addr - 'h1F0) % 16;
    if (mode == 2 && addr >= 'h3F0 && addr <= 'h3FF) return (addr - 'h3E8) % 16;
    if (mode == 3 && addr >= 'h170 && addr <= 'h17F) return (addr - 'h170) % 16;
    if (mode == 3 && addr >= 'h370 && addr <= 'h37F) return (addr - 'h368) % 16;
    return addr % 16;
  endfunction

  task automatic step(input int mode, input int addr, input bit rd, input bit wr,
                      input int val, input int sel, input int st, input bit pres,
                      input int core, input string tag);
    int s, eIdx, eRd, eStb;
    bit w, r;
    @(negedge clk);
    modeSel = 6'(mode); accAddr = 16'(addr); rdStb = rd; wrStb = wr;
    wrLowByte = 8'(val); devHeadLow = 4'(sel); coreStatus = 8'(st);
    drivePresent = pres; coreRdData = 16'(core);
    #1;
    s = refSlot(mode, addr);
    w = wr; r = rd && !wr;
    eIdx = s; eRd = core; eStb = 0; // {dataRd,dataWr,coreRd,coreWr,ctrlWr}
    case (s)
      0, 8: begin eIdx = 0; eStb = {r, w, 3'b000}; end
      9:    begin eRd = mOdd; end
      13:   begin eIdx = 1; eStb = {2'b00, r, w, 1'b0}; end
      14:   begin eRd = pres ? st : 0; eStb = {4'b0000, w}; end
      15:   begin eRd = 'hC2 | ((~sel << 2) & 'h3C); eStb = {3'b000, w, 1'b0}; end
      default: eStb = {2'b00, r, w, 1'b0};
    endcase
    chk(tag, "slot", int'(slotIdx), s);
    chk(tag, "strobes", int'({dataRdStb, dataWrStb, coreRdStb, coreWrStb, devCtrlWrStb}), eStb);
    chk(tag, "coreRegIdx", int'(coreRegIdx), eIdx);
    chk(tag, "rdData", int'(rdData), eRd & 'hFFFF);
    chk("R11", "oddByte", int'(oddByte), mOdd);
    chk("R11", "byteCycle", int'(byteCycle), mCyc);
    @(posedge clk);
    if (w && s == 9) begin mOdd = val & 'hFF; mCyc ^= 1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "oddByte after reset", int'(oddByte), 0);
    chk("R1", "byteCycle after reset", int'(byteCycle), 0);

    // R2: memory-mapped window edges and neighbours
    step(0, 'h400, 1, 0, 0, 0, 0, 1, 'h1234, "R2");
    step(0, 'h7FF, 1, 0, 0, 0, 0, 1, 'h5678, "R2");
    step(0, 'h5A3, 0, 1, 0, 0, 0, 1, 0, "R2");
    step(0, 'h3FF, 1, 0, 0, 0, 0, 1, 'h0101, "R6");
    step(0, 'h805, 1, 0, 0, 0, 0, 1, 'h0202, "R6");
    // R3: contiguous I/O
    step(1, 'h1234, 1, 0, 0, 0, 0, 1, 'hABCD, "R3");
    step(1, 'h0407, 0, 1, 0, 0, 0, 1, 0, "R3");
    // R4: primary legacy
    step(2, 'h1F0, 1, 0, 0, 0, 0, 1, 'h1111, "R4");
    step(2, 'h1F7, 0, 1, 0, 0, 0, 1, 0, "R4");
    step(2, 'h3F6, 1, 0, 0, 0, 'h50, 1, 0, "R4");
    step(2, 'h3F7, 1, 0, 0, 'h3, 0, 1, 0, "R4");
    step(2, 'h3F0, 1, 0, 0, 0, 0, 1, 'h2222, "R4");
    step(2, 'h3F9, 1, 0, 0, 0, 0, 1, 'h3333, "R4");
    step(2, 'h176, 1, 0, 0, 0, 0, 1, 'h4444, "R6");
    // R5: secondary legacy
    step(3, 'h172, 1, 0, 0, 0, 0, 1, 'h5555, "R5");
    step(3, 'h376, 0, 1, 0, 0, 0, 1, 0, "R5");
    step(3, 'h377, 1, 0, 0, 'hA, 0, 1, 0, "R5");
    step(3, 'h1F6, 1, 0, 0, 0, 0, 1, 'h6666, "R6");
    // R6: undefined modes
    step(5, 'h3F6, 1, 0, 0, 0, 0, 1, 'h7777, "R6");
    step(63, 'h42B, 0, 1, 0, 0, 0, 1, 0, "R6");
    // R7: data aliases
    step(1, 'h0, 0, 1, 0, 0, 0, 1, 0, "R7");
    step(1, 'h8, 1, 0, 0, 0, 0, 1, 'hBEEF, "R7");
    // R8: error / features
    step(1, 'hD, 1, 0, 0, 0, 0, 1, 'h0004, "R8");
    step(1, 'hD, 0, 1, 0, 0, 0, 1, 0, "R8");
    // R9: alternate status / device control
    step(1, 'hE, 1, 0, 0, 0, 'h58, 1, 'hFFFF, "R9");
    step(1, 'hE, 1, 0, 0, 0, 'h58, 0, 'hFFFF, "R9");
    step(1, 'hE, 0, 1, 'h04, 0, 0, 1, 0, "R9");
    // R10: device address register
    for (int k = 0; k < 16; k += 5) step(1, 'hF, 1, 0, 0, k, 0, 1, 'hFFFF, "R10");
    step(1, 'hF, 0, 1, 0, 0, 0, 1, 0, "R10");
    // R11: odd-byte latch, two toggles, read-back, other slots leave it alone
    step(1, 'h9, 0, 1, 'hA5, 0, 0, 1, 0, "R11");
    step(1, 'h9, 1, 0, 0, 0, 0, 1, 'hFFFF, "R11");
    step(1, 'h9, 0, 1, 'h3C, 0, 0, 1, 0, "R11");
    step(1, 'h0, 0, 1, 'hEE, 0, 0, 1, 0, "R11");
    step(1, 'h9, 1, 0, 0, 0, 0, 1, 0, "R11");
    // R12: forwarded slots
    for (int k = 1; k < 13; k++) begin
      if (k != 8 && k != 9) begin
        step(1, k, 1, 0, 0, 0, 0, 1, 'h100 + k, "R12");
        step(1, k, 0, 1, 0, 0, 0, 1, 0, "R12");
      end
    end
    // R13: idle and read+write together
    step(1, 'h3, 0, 0, 0, 0, 0, 1, 'h99, "R13");
    step(1, 'h3, 1, 1, 0, 0, 0, 1, 'h99, "R13");
    step(1, 'h9, 1, 1, 'h77, 0, 0, 1, 0, "R13");
    step(1, 'hE, 1, 1, 0, 0, 'h50, 1, 0, "R13");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int m, a;
      m = ($urandom % 5 == 4) ? int'($urandom % 64) : int'($urandom % 4);
      case ($urandom % 4)
        0: a = 'h400 + int'($urandom % 'h400);
        1: a = (($urandom % 2) ? 'h1F0 : 'h170) + int'($urandom % 16);
        2: a = (($urandom % 2) ? 'h3F0 : 'h370) + int'($urandom % 16);
        default: a = int'($urandom % 'h10000);
      endcase
      step(m, a, 1'($urandom), 1'($urandom), int'($urandom % 256), int'($urandom % 16),
           int'($urandom % 256), 1'($urandom), int'($urandom % 'h10000), "R13");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule